// File: doc/BRIEF.md
# DMA Stream Data Buffer with Threshold and Direct Modes

This block is the word buffer that sits between the peripheral side and the memory side of one DMA stream. It holds up to four 32-bit words in order. The stream controller enables it with a direction and a mode. The buffer then tells the memory side, through a single request line, when a memory access is due.

In buffered mode, requests follow a programmable fill threshold. When data flows toward memory, a drain is requested once enough words are stored. When data flows from memory, a fill is requested once enough space is free. In direct mode the buffer holds a single word, so every transfer passes straight through. For memory-to-peripheral traffic in direct mode, one word is fetched in advance so that the peripheral can take it the moment it asks.

The controller is a five-state machine:
- ST_OFF is the disabled, flushed state.
- ST_BUF_DRAIN is buffered mode toward memory.
- ST_BUF_FILL is buffered mode from memory.
- ST_DIR_P2M is direct mode toward memory.
- ST_DIR_M2P is direct mode from memory with preload.

On the clock edge where stream_en is high, ST_OFF moves to one of the four running states, chosen from the configuration seen on that edge. Every running state returns to ST_OFF on any edge where stream_en is low.

Top module: `stream_fifo_buffer`

## Requirements
- R1: After reset, and on every cycle following an edge where stream_en was low, the outputs are empty=1, full=0, mem_req=0, err=0 and rd_data=0.
- R2: Accepted words leave rd_data in the order they were written. rd_data shows the oldest stored word, or 0 when the buffer is empty. In buffered mode full=1 exactly when 4 words are stored.
- R3: In buffered mode with cfg_dir 00 (peripheral to memory), 10 (memory to memory) or 11 (treated as 00), mem_req=1 exactly when the stored count is at least the threshold. The threshold is set by cfg_thr: 00=1, 01=2, 10=3, 11=4 words.
- R4: In buffered mode with cfg_dir 01 (memory to peripheral), mem_req=1 exactly when the free space (4 minus the stored count) is at least the cfg_thr threshold.
- R5: In direct mode (cfg_direct=1) the capacity is one word, and full=1 whenever a word is held.
- R6: In direct mode with cfg_dir 00, mem_req=1 exactly while a word is held.
- R7: In direct mode with cfg_dir 01, mem_req=1 from the first enabled cycle while the buffer is empty. It falls once the preloaded word is stored, and it rises again after the peripheral reads that word.
- R8: With cfg_dir 10, cfg_direct is ignored and the stream runs in buffered mode.
- R9: A write while full, or a read while empty, is ignored and sets err. err stays set while the stream remains enabled.
- R10: cfg_dir, cfg_direct and cfg_thr are sampled only on the enabling edge. Changes while enabled have no effect until the stream is disabled and enabled again.
- R11: Disabling the stream discards all stored words and clears err. Writes and reads on edges where the stream is disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stream_en | input | 1 | Stream enable; low flushes the buffer |
| cfg_direct | input | 1 | 1 selects direct mode |
| cfg_thr | input | 2 | Buffered-mode threshold code |
| cfg_dir | input | 2 | Transfer direction code |
| wr_valid | input | 1 | Write strobe from the producing side |
| wr_data | input | 32 | Write word |
| rd_valid | input | 1 | Read strobe from the consuming side |
| rd_data | output | 32 | Oldest stored word, or 0 when empty |
| mem_req | output | 1 | Request toward the memory side |
| full | output | 1 | Buffer at capacity for the current mode |
| empty | output | 1 | No word stored |
| err | output | 1 | Sticky overflow or underflow flag |

## Verification
Directed runs step each threshold code through every fill level in both buffered directions. This separates the count-based drain rule from the space-based fill rule, and it exposes any off-by-one at the threshold edge. Direct-mode runs in each direction tell the preload behaviour apart from pass-through. Memory-to-memory runs with the direct bit set show whether that bit is wrongly honoured. Constrained random traffic mixes reads, writes, overflow and underflow attempts, mid-run configuration changes and disable pulses. Every cycle is compared with a queue model, which catches ordering, flush and sticky-flag faults.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    typedef enum logic [1:0] {
        DIR_P2M = 2'b00,
        DIR_M2P = 2'b01,
        DIR_M2M = 2'b10,
        DIR_RSV = 2'b11
    } xfer_dir_e;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_BUF_DRAIN = 3'd1,
        ST_BUF_FILL  = 3'd2,
        ST_DIR_P2M   = 3'd3,
        ST_DIR_M2P   = 3'd4
    } sfb_state_e;
endpackage

// File: rtl/sfb_store.sv
module sfb_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level
);
    logic [DW-1:0] slots [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            unique case ({push, pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    assign rdata = (level == '0) ? '0 : slots[rptr];
endmodule

// File: rtl/sfb_thr_dec.sv
module sfb_thr_dec #(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    thr_code,
    output logic [LW-1:0] thr_words
);
    // Quarter steps of the depth: code 0..3 -> 1/4 .. 4/4.
    always_comb begin
        int q;
        q = ((int'(thr_code) + 1) * DEPTH) / 4;
        if (q < 1) q = 1;
        thr_words = LW'(q);
    end
endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
    import sfb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stream_en,
    input  logic          cfg_direct,
    input  logic [1:0]    cfg_thr,
    input  logic [1:0]    cfg_dir,
    input  logic          wr_valid,
    input  logic          rd_valid,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] thr_words,
    output logic [1:0]    thr_q,
    output logic          push,
    output logic          pop,
    output logic          flush,
    output logic          mem_req,
    output logic          full,
    output logic          empty,
    output logic          err
);
    sfb_state_e    state, nxt;
    logic [LW-1:0] cap;
    logic          run;

    function automatic sfb_state_e pick(input logic [1:0] dir, input logic dct);
        xfer_dir_e d;
        d = xfer_dir_e'(dir);
        if (dct && d == DIR_M2P)      return ST_DIR_M2P;
        else if (dct && d != DIR_M2M) return ST_DIR_P2M;
        else if (d == DIR_M2P)        return ST_BUF_FILL;
        else                          return ST_BUF_DRAIN;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:       if (stream_en) nxt = pick(cfg_dir, cfg_direct);
            ST_BUF_DRAIN,
            ST_BUF_FILL,
            ST_DIR_P2M,
            ST_DIR_M2P:   if (!stream_en) nxt = ST_OFF;
            default:      nxt = ST_OFF;
        endcase
    end

    // Threshold is captured only on the enabling edge
    always_ff @(posedge clk) begin
        if (!rst_n)                          thr_q <= '0;
        else if (state == ST_OFF && stream_en) thr_q <= cfg_thr;
    end

    // Per-state outputs
    always_comb begin
        cap     = '0;
        mem_req = 1'b0;
        unique case (state)
            ST_OFF: begin
                cap     = '0;
                mem_req = 1'b0;
            end
            ST_BUF_DRAIN: begin
                cap     = LW'(DEPTH);
                mem_req = (level >= thr_words);
            end
            ST_BUF_FILL: begin
                cap     = LW'(DEPTH);
                mem_req = ((LW'(DEPTH) - level) >= thr_words);
            end
            ST_DIR_P2M: begin
                cap     = LW'(1);
                mem_req = (level != '0);
            end
            ST_DIR_M2P: begin
                cap     = LW'(1);
                mem_req = (level == '0);
            end
            default: begin
                cap     = '0;
                mem_req = 1'b0;
            end
        endcase
    end

    assign run   = (state != ST_OFF) && stream_en;
    assign push  = run && wr_valid && (level < cap);
    assign pop   = run && rd_valid && (level != '0);
    assign flush = !run;
    assign full  = (state != ST_OFF) && (level == cap);
    assign empty = (level == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || !run)                                err <= 1'b0;
        else if ((wr_valid && !push) || (rd_valid && !pop)) err <= 1'b1;
    end
endmodule

// File: rtl/stream_fifo_buffer.sv
module stream_fifo_buffer #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stream_en,
    input  logic          cfg_direct,
    input  logic [1:0]    cfg_thr,
    input  logic [1:0]    cfg_dir,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic          full,
    output logic          empty,
    output logic          err
);
    logic [LW-1:0] level, thr_words;
    logic [1:0]    thr_q;
    logic          push, pop, flush;

    sfb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .stream_en(stream_en),
        .cfg_direct(cfg_direct), .cfg_thr(cfg_thr), .cfg_dir(cfg_dir),
        .wr_valid(wr_valid), .rd_valid(rd_valid),
        .level(level), .thr_words(thr_words), .thr_q(thr_q),
        .push(push), .pop(pop), .flush(flush),
        .mem_req(mem_req), .full(full), .empty(empty), .err(err)
    );

    sfb_thr_dec #(.DEPTH(DEPTH)) u_thr (
        .thr_code(thr_q), .thr_words(thr_words)
    );

    sfb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push), .pop(pop), .wdata(wr_data),
        .rdata(rd_data), .level(level)
    );
endmodule

// File: rtl/sfb_chk.sv
module sfb_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stream_en,
    input logic          wr_valid,
    input logic          rd_valid,
    input logic [DW-1:0] rd_data,
    input logic          mem_req,
    input logic          full,
    input logic          empty,
    input logic          err
);
    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_en |=> (empty && !full && !mem_req && !err));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && stream_en) |=> err);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && stream_en && !rd_valid) |=> (full && $stable(rd_data)));

    // R11
    flush_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stream_en) |=> (empty && !err));

    // R2
    empty_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rd_data == '0 && !full));
endmodule

bind stream_fifo_buffer sfb_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .stream_en(stream_en),
    .wr_valid(wr_valid), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_req(mem_req), .full(full), .empty(empty), .err(err)
);

// File: tb/tb_stream_fifo_buffer.sv
`timescale 1ns/1ps
module tb_stream_fifo_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stream_en = 1'b0, cfg_direct = 1'b0, wr_valid = 1'b0, rd_valid = 1'b0;
    logic [1:0]  cfg_thr = 2'b00, cfg_dir = 2'b00;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mem_req, full, empty, err;

    int checks = 0, fails = 0;

    // model state
    bit          m_on = 0, m_dct = 0, m_err = 0;
    logic [1:0]  m_dir = 0, m_thr = 0;
    logic [31:0] q[$];

    always #4 clk = ~clk;

    stream_fifo_buffer dut (
        .clk(clk), .rst_n(rst_n), .stream_en(stream_en),
        .cfg_direct(cfg_direct), .cfg_thr(cfg_thr), .cfg_dir(cfg_dir),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_req(mem_req), .full(full), .empty(empty), .err(err)
    );

    function automatic bit eff_direct();
        return m_dct && (m_dir != 2'b10);
    endfunction

    function automatic int cap_now();
        if (!m_on) return 0;
        return eff_direct() ? 1 : 4;
    endfunction

    function automatic bit exp_req();
        int n;
        n = q.size();
        if (!m_on) return 0;
        if (eff_direct()) return (m_dir == 2'b01) ? (n == 0) : (n == 1);
        if (m_dir == 2'b01) return (4 - n) >= (int'(m_thr) + 1);
        return n >= (int'(m_thr) + 1);
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "empty",   32'(empty),   32'(q.size() == 0));
        cmp(tag, "full",    32'(full),    32'(m_on && q.size() == cap_now()));
        cmp(tag, "mem_req", 32'(mem_req), 32'(exp_req()));
        cmp(tag, "err",     32'(err),     32'(m_err));
        cmp(tag, "rd_data", rd_data, (q.size() != 0) ? q[0] : 32'h0);
    endtask

    // called at negedge: check, drive, update model, advance one cycle
    task automatic step(input string tag, input bit en, input logic [1:0] dir, input bit dct,
                        input logic [1:0] thr, input bit wr, input logic [31:0] wd, input bit rd);
        bit wok, rok;
        check_all(tag);
        stream_en = en; cfg_dir = dir; cfg_direct = dct; cfg_thr = thr;
        wr_valid = wr; wr_data = wd; rd_valid = rd;
        if (!m_on) begin
            if (en) begin m_on = 1; m_dir = dir; m_dct = dct; m_thr = thr; end
            q.delete(); m_err = 0;
        end else if (!en) begin
            m_on = 0; q.delete(); m_err = 0;
        end else begin
            wok = wr && (q.size() < cap_now());
            rok = rd && (q.size() > 0);
            if ((wr && !wok) || (rd && !rok)) m_err = 1;
            if (rok) void'(q.pop_front());
            if (wok) q.push_back(wd);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input bit en, input logic [1:0] dir, input bit dct, input logic [1:0] thr);
        step(tag, en, dir, dct, thr, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        bit en;
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_all("R1");
        rst_n = 1'b1;
        idle("R1", 0, 0, 0, 0);

        // R3 drain threshold sweep, R2 ordering
        for (int t = 0; t < 4; t++) begin
            idle("R3", 1, 2'b00, 0, 2'(t));
            for (int k = 0; k < 4; k++) step("R3", 1, 2'b00, 0, 2'(t), 1, 32'hA000 + 32'(k), 0);
            for (int k = 0; k < 4; k++) step("R2", 1, 2'b00, 0, 2'(t), 0, 0, 1);
            idle("R11", 0, 2'b00, 0, 2'(t));
        end
        // R4 fill threshold sweep
        for (int t = 0; t < 4; t++) begin
            idle("R4", 1, 2'b01, 0, 2'(t));
            for (int k = 0; k < 4; k++) step("R4", 1, 2'b01, 0, 2'(t), 1, 32'hB000 + 32'(k), 0);
            step("R9", 1, 2'b01, 0, 2'(t), 1, 32'hDEAD, 0);
            for (int k = 0; k < 4; k++) step("R4", 1, 2'b01, 0, 2'(t), 0, 0, 1);
            idle("R11", 0, 2'b01, 0, 2'(t));
        end
        // R5 R6 direct toward memory
        idle("R6", 1, 2'b00, 1, 2'b11);
        step("R6", 1, 2'b00, 1, 2'b11, 1, 32'h1111, 0);
        step("R5", 1, 2'b00, 1, 2'b11, 1, 32'h2222, 0);
        step("R6", 1, 2'b00, 1, 2'b11, 0, 0, 1);
        step("R9", 1, 2'b00, 1, 2'b11, 0, 0, 1);
        idle("R11", 0, 2'b00, 1, 2'b11);
        // R7 direct from memory with preload
        idle("R7", 1, 2'b01, 1, 2'b00);
        step("R7", 1, 2'b01, 1, 2'b00, 1, 32'h3333, 0);
        step("R7", 1, 2'b01, 1, 2'b00, 0, 0, 1);
        step("R7", 1, 2'b01, 1, 2'b00, 1, 32'h4444, 0);
        idle("R11", 0, 2'b01, 1, 2'b00);
        // R8 memory-to-memory ignores direct bit
        idle("R8", 1, 2'b10, 1, 2'b01);
        for (int k = 0; k < 4; k++) step("R8", 1, 2'b10, 1, 2'b01, 1, 32'hC000 + 32'(k), 0);
        idle("R8", 0, 2'b10, 1, 2'b01);
        // R10 config changes while enabled ignored
        idle("R10", 1, 2'b00, 0, 2'b00);
        step("R10", 1, 2'b01, 1, 2'b11, 1, 32'h5555, 0);
        step("R10", 1, 2'b01, 1, 2'b11, 1, 32'h6666, 0);
        idle("R10", 1, 2'b01, 1, 2'b11);
        // R11 disable flushes, then re-enable empty
        idle("R11", 0, 2'b00, 0, 2'b10);
        step("R11", 0, 2'b00, 0, 2'b10, 1, 32'h7777, 1);
        idle("R11", 1, 2'b00, 0, 2'b10);
        idle("R11", 1, 2'b00, 0, 2'b10);

        // constrained random mix
        en = 1;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 100) < 3) en = !en;
            step("R2", en, 2'($urandom), ($urandom % 4) == 0, 2'($urandom),
                 ($urandom % 2) == 0, $urandom, ($urandom % 2) == 0);
        end
        check_all("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule